// File: doc/BRIEF.md
# Secure Memory Region Access Filter

This block guards one system interface of a memory controller. It holds a parameterised set of numbered address regions. Each region has a base, an inclusive top, a two-bit security attribute, an enable bit and a 32-bit word of per-ID read and write permissions. Each transaction that reaches the interface carries an address, a secure flag, a read/write flag and a 4-bit ID. The filter checks the transaction against the active region set and answers permit or deny one cycle later. When the configured failure action asks for it, a deny also sets a sticky interrupt flag.

Software programs the filter through a simple 32-bit register port with a single-cycle write strobe and a combinational read. Every region write lands in a shadow copy. The filter keeps using the old active copy until software writes 1 to the flush register. A fixed number of cycles later the whole shadow set is copied into the active set in one step. Software confirms that the flush has finished by reading back a region's attribute word, which always shows the active value.

Region 0 is the fallback for every address that no other enabled region claims. It cannot be disabled and has no address bounds. Only its attribute and permission word can be written.

Top module: `mem_region_guard`

## Requirements
- R1: After reset, txn_permit, txn_deny and irq_flag are 0. All shadow and active region fields are 0, except the enable of region 0, which is 1. The failure action is 0. So every transaction is denied until a configuration is flushed.
- R2: Region n (0 ≤ n < NUM_REGIONS) owns a 0x20-byte group at 0x054 + n·0x20, with these words:
  - +0x00: base address bits [31:12] in data [31:12]; reads with [11:0] = 0.
  - +0x04: base address bits [42:32] in data [10:0].
  - +0x08: top address bits [31:12]; reads with [11:0] = 0xFFF.
  - +0x0C: top address bits [42:32].
  - +0x10: attribute.
  - +0x14: permission word.
  Base, top and permission words read back their shadow values.
- R3: Region writes do not change filtering until 1 is written to bit 0 of offset 0x00C. The active set is replaced at the second rising edge after the edge that takes the flush write. A transaction sampled at that edge or earlier is judged on the old set.
- R4: The attribute word holds the security attribute in [31:30] and the enable in [0]. It reads back the active value, not the shadow value.
- R5: Region 0 matches any address no other enabled region matches. Writes to its base and top words are ignored, and those words read 0. Its enable always reads 1, whatever is written to it.
- R6: A region n ≥ 1 matches when its enable is 1 and base[42:12] ≤ addr[42:12] ≤ top[42:12]. Address bits [11:0] take no part in the comparison. A disabled region never matches.
- R7: When several enabled regions match, the one with the highest number decides.
- R8: A secure transaction is judged by the security attribute of the deciding region: 00 none, 01 read only, 10 write only, 11 read and write.
- R9: A non-secure transaction with ID i is permitted for a read when bit i of the deciding region's permission word is 1. It is permitted for a write when bit 16+i is 1.
- R10: For each cycle with txn_valid high, exactly one of txn_permit and txn_deny is high in the following cycle. Both are low after a cycle without txn_valid.
- R11: Bit 0 of offset 0x050 holds the failure action and takes effect at once (0 = deny only, 1 = deny and flag). With action 1, a denied transaction sets irq_flag in the same cycle as its deny pulse. Writing 1 to bit 0 of 0x010 clears the flag. A deny that sets the flag in the same cycle as a clear write wins, and the flag stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 12 | Register byte offset for write and read |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr (combinational) |
| txn_valid | input | 1 | Transaction present this cycle |
| txn_addr | input | ADDR_W | Transaction address |
| txn_secure | input | 1 | 1 = secure transaction |
| txn_write | input | 1 | 1 = write, 0 = read |
| txn_id | input | ID_BITS | Non-secure master ID |
| txn_permit | output | 1 | Transaction of the previous cycle permitted |
| txn_deny | output | 1 | Transaction of the previous cycle denied (pulse) |
| irq_flag | output | 1 | Sticky failure flag |

## Verification
Two pairs of functions can meet in one cycle, and the bench provokes each pair on purpose.

The first pair is a transaction check and the active-set swap. The bench writes the flush command and then holds one secure write on the interface for three cycles. The region-0 attribute that governs that write differs between the shadow set and the active set. The bench expects deny for the first two results and permit only for the third.

The second pair is a flag clear and a deny that raises the flag. The bench puts a clear write and a denied transaction into the same cycle and expects the flag to remain set. A later clear on its own must then drop the flag.

// File: rtl/mrg_pkg.sv
package mrg_pkg;
   localparam int unsigned CFG_AW        = 12;
   localparam int unsigned GRP_STRIDE_LG = 5;
   localparam logic [CFG_AW-1:0] OFS_FLUSH  = 12'h00C;
   localparam logic [CFG_AW-1:0] OFS_CLEAR  = 12'h010;
   localparam logic [CFG_AW-1:0] OFS_ACTION = 12'h050;
   localparam logic [CFG_AW-1:0] OFS_GROUP0 = 12'h054;

   typedef enum logic [2:0] {
      W_BASE_LO = 3'd0,
      W_BASE_HI = 3'd1,
      W_TOP_LO  = 3'd2,
      W_TOP_HI  = 3'd3,
      W_ATTR    = 3'd4,
      W_IDPERM  = 3'd5
   } grp_word_e;

   typedef enum logic [1:0] {
      SEC_NONE = 2'b00,
      SEC_RD   = 2'b01,
      SEC_WR   = 2'b10,
      SEC_RW   = 2'b11
   } sec_attr_e;
endpackage

// File: rtl/mrg_cfg.sv
module mrg_cfg
   import mrg_pkg::*;
#(
   parameter int unsigned NUM_REGIONS = 8,
   parameter int unsigned PAGE_W      = 31,
   parameter int unsigned PAGE_LSB    = 12,
   parameter int unsigned FLUSH_LAT   = 2
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               wr,
   input  logic [CFG_AW-1:0]                  addr,
   input  logic [31:0]                        wdata,
   output logic [31:0]                        rdata,
   output logic [NUM_REGIONS-1:0][PAGE_W-1:0] act_base,
   output logic [NUM_REGIONS-1:0][PAGE_W-1:0] act_top,
   output logic [NUM_REGIONS-1:0][1:0]        act_sec,
   output logic [NUM_REGIONS-1:0]             act_en,
   output logic [NUM_REGIONS-1:0][31:0]       act_perm,
   output logic                               action_q,
   output logic                               clear_req
);
   localparam int unsigned RIDX_W = $clog2(NUM_REGIONS);
   localparam int unsigned LO_PG  = 32 - PAGE_LSB;
   localparam int unsigned HI_W   = PAGE_W - LO_PG;
   localparam int unsigned CNT_W  = $clog2(FLUSH_LAT + 1);
   localparam logic [CFG_AW-1:0] GRP_SPAN = CFG_AW'(NUM_REGIONS << GRP_STRIDE_LG);

   logic [NUM_REGIONS-1:0][PAGE_W-1:0] sh_base, sh_top;
   logic [NUM_REGIONS-1:0][1:0]        sh_sec;
   logic [NUM_REGIONS-1:0]             sh_en;
   logic [NUM_REGIONS-1:0][31:0]       sh_perm;
   logic [CNT_W-1:0]                   flush_cnt;

   logic [CFG_AW-1:0] rel;
   logic              in_grp, grp_wr, flush_wr, swap, is_r0;
   logic [RIDX_W-1:0] ridx;
   grp_word_e         word;

   assign rel    = addr - OFS_GROUP0;
   assign ridx   = rel[GRP_STRIDE_LG +: RIDX_W];
   assign word   = grp_word_e'(rel[4:2]);
   assign in_grp = (addr >= OFS_GROUP0) && (rel < GRP_SPAN) &&
                   (addr[1:0] == 2'b00) && (rel[4:2] <= 3'd5);
   assign is_r0  = (ridx == '0);
   assign grp_wr = wr && in_grp;
   assign flush_wr  = wr && (addr == OFS_FLUSH) && wdata[0];
   assign clear_req = wr && (addr == OFS_CLEAR) && wdata[0];
   assign swap      = (flush_cnt == CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_base   <= '0;
         sh_top    <= '0;
         sh_sec    <= '0;
         sh_en     <= NUM_REGIONS'(1);
         sh_perm   <= '0;
         act_base  <= '0;
         act_top   <= '0;
         act_sec   <= '0;
         act_en    <= NUM_REGIONS'(1);
         act_perm  <= '0;
         action_q  <= 1'b0;
         flush_cnt <= '0;
      end else begin
         if (grp_wr) begin
            case (word)
               W_BASE_LO: if (!is_r0) sh_base[ridx][LO_PG-1:0]      <= wdata[31:PAGE_LSB];
               W_BASE_HI: if (!is_r0) sh_base[ridx][PAGE_W-1:LO_PG] <= wdata[HI_W-1:0];
               W_TOP_LO:  if (!is_r0) sh_top[ridx][LO_PG-1:0]       <= wdata[31:PAGE_LSB];
               W_TOP_HI:  if (!is_r0) sh_top[ridx][PAGE_W-1:LO_PG]  <= wdata[HI_W-1:0];
               W_ATTR: begin
                  sh_sec[ridx] <= wdata[31:30];
                  if (!is_r0) sh_en[ridx] <= wdata[0];
               end
               W_IDPERM:  sh_perm[ridx] <= wdata;
               default: ;
            endcase
         end
         if (wr && (addr == OFS_ACTION)) action_q <= wdata[0];
         if (flush_wr)               flush_cnt <= CNT_W'(FLUSH_LAT);
         else if (flush_cnt != '0)   flush_cnt <= flush_cnt - CNT_W'(1);
         if (swap) begin
            act_base <= sh_base;
            act_top  <= sh_top;
            act_sec  <= sh_sec;
            act_en   <= sh_en;
            act_perm <= sh_perm;
         end
      end
   end

   always_comb begin
      rdata = '0;
      if (addr == OFS_ACTION) begin
         rdata[0] = action_q;
      end else if (in_grp) begin
         case (word)
            W_BASE_LO: if (!is_r0) rdata = {sh_base[ridx][LO_PG-1:0], {PAGE_LSB{1'b0}}};
            W_BASE_HI: if (!is_r0) rdata = 32'(sh_base[ridx][PAGE_W-1:LO_PG]);
            W_TOP_LO:  if (!is_r0) rdata = {sh_top[ridx][LO_PG-1:0], {PAGE_LSB{1'b1}}};
            W_TOP_HI:  if (!is_r0) rdata = 32'(sh_top[ridx][PAGE_W-1:LO_PG]);
            W_ATTR:    rdata = {act_sec[ridx], 29'b0, act_en[ridx]};
            W_IDPERM:  rdata = sh_perm[ridx];
            default:   rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/mrg_lookup.sv
module mrg_lookup
   import mrg_pkg::*;
#(
   parameter int unsigned NUM_REGIONS = 8,
   parameter int unsigned PAGE_W      = 31,
   parameter int unsigned ID_BITS     = 4
) (
   input  logic [PAGE_W-1:0]                  page,
   input  logic                               secure,
   input  logic                               write,
   input  logic [ID_BITS-1:0]                 id,
   input  logic [NUM_REGIONS-1:0][PAGE_W-1:0] act_base,
   input  logic [NUM_REGIONS-1:0][PAGE_W-1:0] act_top,
   input  logic [NUM_REGIONS-1:0][1:0]        act_sec,
   input  logic [NUM_REGIONS-1:0]             act_en,
   input  logic [NUM_REGIONS-1:0][31:0]       act_perm,
   output logic                               allow
);
   localparam int unsigned RIDX_W  = $clog2(NUM_REGIONS);
   localparam int unsigned N_IDS   = 1 << ID_BITS;

   logic [NUM_REGIONS-1:0] hit;
   logic [RIDX_W-1:0]      sel;
   logic [1:0]             sec;
   logic [N_IDS-1:0]       rd_ok, wr_ok;

   assign hit[0] = 1'b1;
   for (genvar g = 1; g < NUM_REGIONS; g++) begin : g_hit
      assign hit[g] = act_en[g] && (page >= act_base[g]) && (page <= act_top[g]);
   end

   always_comb begin
      sel = '0;
      for (int i = 1; i < NUM_REGIONS; i++) begin
         if (hit[i]) sel = RIDX_W'(i);
      end
   end

   assign sec   = act_sec[sel];
   assign rd_ok = act_perm[sel][N_IDS-1:0];
   assign wr_ok = act_perm[sel][2*N_IDS-1:N_IDS];
   assign allow = secure ? (write ? sec[1] : sec[0])
                         : (write ? wr_ok[id] : rd_ok[id]);
endmodule

// File: rtl/mem_region_guard.sv
module mem_region_guard
   import mrg_pkg::*;
#(
   parameter int unsigned NUM_REGIONS = 8,
   parameter int unsigned ADDR_W      = 43,
   parameter int unsigned PAGE_LSB    = 12,
   parameter int unsigned ID_BITS     = 4,
   parameter int unsigned FLUSH_LAT   = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_wr,
   input  logic [11:0]        cfg_addr,
   input  logic [31:0]        cfg_wdata,
   output logic [31:0]        cfg_rdata,
   input  logic               txn_valid,
   input  logic [ADDR_W-1:0]  txn_addr,
   input  logic               txn_secure,
   input  logic               txn_write,
   input  logic [ID_BITS-1:0] txn_id,
   output logic               txn_permit,
   output logic               txn_deny,
   output logic               irq_flag
);
   localparam int unsigned PAGE_W = ADDR_W - PAGE_LSB;

   if (NUM_REGIONS < 2 || NUM_REGIONS > 32) begin : g_bad_regions
      $error("NUM_REGIONS must lie in 2..32");
   end
   if (ADDR_W <= 32 || ADDR_W > 64) begin : g_bad_addr
      $error("ADDR_W must lie in 33..64");
   end
   if (PAGE_LSB != 12) begin : g_bad_page
      $error("PAGE_LSB must be 12");
   end
   if (ID_BITS != 4) begin : g_bad_id
      $error("ID_BITS must be 4 to fit the 32-bit permission word");
   end
   if (FLUSH_LAT < 1) begin : g_bad_flush
      $error("FLUSH_LAT must be at least 1");
   end

   logic [NUM_REGIONS-1:0][PAGE_W-1:0] act_base, act_top;
   logic [NUM_REGIONS-1:0][1:0]        act_sec;
   logic [NUM_REGIONS-1:0]             act_en;
   logic [NUM_REGIONS-1:0][31:0]       act_perm;
   logic                               action_q, clear_req, allow;
   logic                               unused_offset;

   assign unused_offset = ^txn_addr[PAGE_LSB-1:0];

   mrg_cfg #(
      .NUM_REGIONS (NUM_REGIONS),
      .PAGE_W      (PAGE_W),
      .PAGE_LSB    (PAGE_LSB),
      .FLUSH_LAT   (FLUSH_LAT)
   ) i_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (cfg_wr),
      .addr      (cfg_addr),
      .wdata     (cfg_wdata),
      .rdata     (cfg_rdata),
      .act_base  (act_base),
      .act_top   (act_top),
      .act_sec   (act_sec),
      .act_en    (act_en),
      .act_perm  (act_perm),
      .action_q  (action_q),
      .clear_req (clear_req)
   );

   mrg_lookup #(
      .NUM_REGIONS (NUM_REGIONS),
      .PAGE_W      (PAGE_W),
      .ID_BITS     (ID_BITS)
   ) i_lookup (
      .page     (txn_addr[ADDR_W-1:PAGE_LSB]),
      .secure   (txn_secure),
      .write    (txn_write),
      .id       (txn_id),
      .act_base (act_base),
      .act_top  (act_top),
      .act_sec  (act_sec),
      .act_en   (act_en),
      .act_perm (act_perm),
      .allow    (allow)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         txn_permit <= 1'b0;
         txn_deny   <= 1'b0;
         irq_flag   <= 1'b0;
      end else begin
         txn_permit <= txn_valid && allow;
         txn_deny   <= txn_valid && !allow;
         if (txn_valid && !allow && action_q) irq_flag <= 1'b1;
         else if (clear_req)                  irq_flag <= 1'b0;
      end
   end
endmodule

// File: rtl/mrg_checker.sv
module mrg_checker
   import mrg_pkg::*;
#(
   parameter int unsigned NUM_REGIONS = 8,
   parameter int unsigned FLUSH_LAT   = 2
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        cfg_wr,
   input logic [11:0]                 cfg_addr,
   input logic [31:0]                 cfg_wdata,
   input logic [31:0]                 cfg_rdata,
   input logic                        txn_valid,
   input logic                        txn_permit,
   input logic                        txn_deny,
   input logic                        irq_flag,
   input logic                        action_q,
   input logic [NUM_REGIONS-1:0][1:0] act_sec,
   input logic [NUM_REGIONS-1:0]      act_en,
   input logic [NUM_REGIONS-1:0][31:0] act_perm
);
   localparam int unsigned AGE_W = $clog2(FLUSH_LAT + 3);

   logic [AGE_W-1:0] flush_age;
   logic             flush_seen, clear_seen;

   assign flush_seen = cfg_wr && (cfg_addr == OFS_FLUSH) && cfg_wdata[0];
   assign clear_seen = cfg_wr && (cfg_addr == OFS_CLEAR) && cfg_wdata[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 flush_age <= '1;
      else if (flush_seen)        flush_age <= AGE_W'(1);
      else if (flush_age != '1)   flush_age <= flush_age + AGE_W'(1);
   end

   p_one_answer_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(txn_permit && txn_deny));
   p_answer_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
      txn_valid |=> (txn_permit || txn_deny));
   p_no_answer_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !txn_valid |=> !(txn_permit || txn_deny));
   p_flag_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_flag) |-> (txn_deny && $past(action_q)));
   p_flag_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_flag && !clear_seen) |=> irq_flag);
   p_swap_timing_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !($stable(act_sec) && $stable(act_en) && $stable(act_perm))
         |-> (flush_age == AGE_W'(FLUSH_LAT + 1)));
   p_region0_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_addr == 12'h064) |-> cfg_rdata[0]);
endmodule

bind mem_region_guard mrg_checker #(
   .NUM_REGIONS (NUM_REGIONS),
   .FLUSH_LAT   (FLUSH_LAT)
) i_mrg_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_wr     (cfg_wr),
   .cfg_addr   (cfg_addr),
   .cfg_wdata  (cfg_wdata),
   .cfg_rdata  (cfg_rdata),
   .txn_valid  (txn_valid),
   .txn_permit (txn_permit),
   .txn_deny   (txn_deny),
   .irq_flag   (irq_flag),
   .action_q   (action_q),
   .act_sec    (act_sec),
   .act_en     (act_en),
   .act_perm   (act_perm)
);

// File: tb/test_mem_region_guard.sv
module test_mem_region_guard;
   localparam int NR = 8;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cfg_wr;
   logic [11:0] cfg_addr;
   logic [31:0] cfg_wdata;
   logic [31:0] cfg_rdata;
   logic        txn_valid;
   logic [42:0] txn_addr;
   logic        txn_secure, txn_write;
   logic [3:0]  txn_id;
   logic        txn_permit, txn_deny, irq_flag;

   always #10 clk = ~clk;

   mem_region_guard i_mem_region_guard (
      .clk (clk), .rst_n (rst_n),
      .cfg_wr (cfg_wr), .cfg_addr (cfg_addr), .cfg_wdata (cfg_wdata), .cfg_rdata (cfg_rdata),
      .txn_valid (txn_valid), .txn_addr (txn_addr), .txn_secure (txn_secure),
      .txn_write (txn_write), .txn_id (txn_id),
      .txn_permit (txn_permit), .txn_deny (txn_deny), .irq_flag (irq_flag)
   );

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   logic [30:0] m_sb [NR], m_st [NR], m_ab [NR], m_at [NR];
   logic [1:0]  m_ss [NR], m_as [NR];
   logic        m_se [NR], m_ae [NR];
   logic [31:0] m_sp [NR], m_ap [NR];
   logic        m_action, m_irq;

   task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int r = 0; r < NR; r++) begin
         m_sb[r] = '0; m_st[r] = '0; m_ss[r] = '0; m_se[r] = (r == 0); m_sp[r] = '0;
         m_ab[r] = '0; m_at[r] = '0; m_as[r] = '0; m_ae[r] = (r == 0); m_ap[r] = '0;
      end
      m_action = 1'b0; m_irq = 1'b0;
   endtask

   task automatic model_write(logic [11:0] a, logic [31:0] d);
      if (a == 12'h050) m_action = d[0];
      else if (a == 12'h010) begin if (d[0]) m_irq = 1'b0; end
      else if (a >= 12'h054 && a < 12'h054 + NR * 32 && a[1:0] == 2'b00) begin
         int r, w;
         r = int'(a - 12'h054) >> 5;
         w = (int'(a - 12'h054) >> 2) & 7;
         case (w)
            0: if (r != 0) m_sb[r][19:0]  = d[31:12];
            1: if (r != 0) m_sb[r][30:20] = d[10:0];
            2: if (r != 0) m_st[r][19:0]  = d[31:12];
            3: if (r != 0) m_st[r][30:20] = d[10:0];
            4: begin m_ss[r] = d[31:30]; if (r != 0) m_se[r] = d[0]; end
            5: m_sp[r] = d;
            default: ;
         endcase
      end
   endtask

   function automatic logic exp_allow(logic [42:0] a, logic s, logic w, logic [3:0] id);
      int sel = 0;
      logic [30:0] pg = a[42:12];
      for (int r = 1; r < NR; r++)
         if (m_ae[r] && pg >= m_ab[r] && pg <= m_at[r]) sel = r;
      if (s) return w ? m_as[sel][1] : m_as[sel][0];
      return w ? m_ap[sel][16 + int'(id)] : m_ap[sel][int'(id)];
   endfunction

   task automatic cfg_write(logic [11:0] a, logic [31:0] d);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_wr = 1'b0;
      model_write(a, d);
   endtask

   task automatic cfg_read(logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      cfg_addr = a;
      #1 d = cfg_rdata;
   endtask

   task automatic flush();
      cfg_write(12'h00C, 32'h1);
      repeat (2) @(negedge clk);
      for (int r = 0; r < NR; r++) begin
         m_ab[r] = m_sb[r]; m_at[r] = m_st[r]; m_as[r] = m_ss[r];
         m_ae[r] = m_se[r]; m_ap[r] = m_sp[r];
      end
   endtask

   task automatic set_region(int r, logic [30:0] bp, logic [30:0] tp, logic [1:0] sec,
                             logic en, logic [31:0] perm);
      logic [11:0] g;
      g = 12'h054 + 12'(r * 32);
      cfg_write(g + 12'h00, {bp[19:0], 12'h000});
      cfg_write(g + 12'h04, 32'(bp[30:20]));
      cfg_write(g + 12'h08, {tp[19:0], 12'hFFF});
      cfg_write(g + 12'h0C, 32'(tp[30:20]));
      cfg_write(g + 12'h10, {sec, 29'b0, en});
      cfg_write(g + 12'h14, perm);
   endtask

   task automatic run_txn(string req, logic [42:0] a, logic s, logic w, logic [3:0] id);
      logic ea;
      ea = exp_allow(a, s, w, id);
      @(negedge clk);
      txn_valid = 1'b1; txn_addr = a; txn_secure = s; txn_write = w; txn_id = id;
      @(negedge clk);
      txn_valid = 1'b0;
      if (!ea && m_action) m_irq = 1'b1;
      check(req, 32'(txn_permit), 32'(ea), "permit");
      check(req, 32'(txn_deny), 32'(!ea), "deny");
      check("R11", 32'(irq_flag), 32'(m_irq), "irq_flag");
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      logic [31:0] rd;
      void'($urandom(32'd4711));
      rst_n = 1'b0; cfg_wr = 1'b0; cfg_addr = '0; cfg_wdata = '0;
      txn_valid = 1'b0; txn_addr = '0; txn_secure = 1'b0; txn_write = 1'b0; txn_id = '0;
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      check("R1", 32'(txn_permit), 0, "permit after reset");
      check("R1", 32'(txn_deny), 0, "deny after reset");
      check("R1", 32'(irq_flag), 0, "irq after reset");
      cfg_read(12'h054 + 12'h060 + 12'h10, rd); check("R1", rd, 32'h0, "region3 attr");
      cfg_read(12'h064, rd); check("R5", rd, 32'h1, "region0 attr after reset");
      cfg_read(12'h050, rd); check("R1", rd, 32'h0, "action");
      run_txn("R1", 43'h123, 1'b1, 1'b0, 4'd0);

      // R2: field layout and shadow readback
      cfg_write(12'h094, 32'h12345678);
      cfg_read(12'h094, rd); check("R2", rd, 32'h12345000, "base lo");
      cfg_write(12'h098, 32'hFFFFFFFF);
      cfg_read(12'h098, rd); check("R2", rd, 32'h000007FF, "base hi");
      cfg_write(12'h09C, 32'h00000ABC);
      cfg_read(12'h09C, rd); check("R2", rd, 32'h00000FFF, "top lo");
      cfg_write(12'h0A8, 32'hA5A50F0F);
      cfg_read(12'h0A8, rd); check("R2", rd, 32'hA5A50F0F, "perm");

      // R4: attribute reads the active value
      cfg_write(12'h0A4, 32'hC0000001);
      cfg_read(12'h0A4, rd); check("R4", rd, 32'h0, "attr before flush");
      flush();
      cfg_read(12'h0A4, rd); check("R4", rd, 32'hC0000001, "attr after flush");
      set_region(2, 31'h0, 31'h0, 2'b00, 1'b0, 32'h0);
      flush();

      // R5: region 0 bounds ignored, enable fixed
      cfg_write(12'h054, 32'hFFFFF000);
      cfg_write(12'h05C, 32'h00001000);
      cfg_read(12'h054, rd); check("R5", rd, 32'h0, "region0 base");
      cfg_read(12'h05C, rd); check("R5", rd, 32'h0, "region0 top");
      cfg_write(12'h064, 32'h40000000);
      flush();
      cfg_read(12'h064, rd); check("R5", rd, 32'h40000001, "region0 attr");
      run_txn("R5", 43'h7FF_FFFF_FFFF, 1'b1, 1'b0, 4'd0);
      run_txn("R8", 43'h000_0000_5000, 1'b1, 1'b1, 4'd0);

      // R3: flush window, transaction meets the swap
      cfg_write(12'h064, 32'hC0000000);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_addr = 12'h00C; cfg_wdata = 32'h1;
      @(negedge clk);
      cfg_wr = 1'b0;
      txn_valid = 1'b1; txn_addr = 43'h3000; txn_secure = 1'b1; txn_write = 1'b1; txn_id = '0;
      @(negedge clk);
      check("R3", 32'(txn_deny), 1, "deny one cycle after flush");
      @(negedge clk);
      check("R3", 32'(txn_deny), 1, "deny at swap edge");
      @(negedge clk);
      check("R3", 32'(txn_permit), 1, "permit after swap");
      txn_valid = 1'b0;
      @(negedge clk);
      check("R10", 32'({txn_permit, txn_deny}), 0, "idle cycle");
      for (int r = 0; r < NR; r++) begin
         m_ab[r] = m_sb[r]; m_at[r] = m_st[r]; m_as[r] = m_ss[r]; m_ae[r] = m_se[r]; m_ap[r] = m_sp[r];
      end

      // R6..R9 directed
      set_region(1, 31'h10, 31'h1F, 2'b00, 1'b1, 32'h0000_0008);
      set_region(5, 31'h18, 31'h18, 2'b11, 1'b1, 32'h0);
      set_region(4, 31'h30, 31'h3F, 2'b00, 1'b0, 32'h0);
      set_region(6, 31'h4000_0000, 31'h4000_000F, 2'b00, 1'b1, 32'h0);
      flush();
      run_txn("R6", 43'h0_0001_2000, 1'b1, 1'b0, 4'd0);
      run_txn("R6", 43'h0_0000_FFFF, 1'b1, 1'b0, 4'd0);
      run_txn("R6", 43'h0_0001_FFFF, 1'b1, 1'b0, 4'd0);
      run_txn("R6", 43'h0_0003_5000, 1'b1, 1'b1, 4'd0);
      run_txn("R6", 43'h400_0000_1234, 1'b1, 1'b0, 4'd0);
      run_txn("R6", 43'h000_0000_1234, 1'b1, 1'b0, 4'd0);
      run_txn("R7", 43'h0_0001_8ABC, 1'b1, 1'b1, 4'd0);
      run_txn("R9", 43'h0_0001_2000, 1'b0, 1'b0, 4'd3);
      run_txn("R9", 43'h0_0001_2000, 1'b0, 1'b1, 4'd3);
      run_txn("R9", 43'h0_0001_2000, 1'b0, 1'b0, 4'd4);

      // R11: action, sticky flag, clear, and clear meeting a deny
      run_txn("R11", 43'h0_0001_2000, 1'b1, 1'b0, 4'd0);
      cfg_write(12'h050, 32'h1);
      run_txn("R11", 43'h0_0001_2000, 1'b1, 1'b0, 4'd0);
      run_txn("R11", 43'h0_0001_8000, 1'b1, 1'b0, 4'd0);
      cfg_write(12'h010, 32'h1);
      @(negedge clk); check("R11", 32'(irq_flag), 0, "flag after clear");
      run_txn("R11", 43'h0_0001_2000, 1'b1, 1'b0, 4'd0);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_addr = 12'h010; cfg_wdata = 32'h1;
      txn_valid = 1'b1; txn_addr = 43'h0_0001_2000; txn_secure = 1'b1; txn_write = 1'b0;
      @(negedge clk);
      cfg_wr = 1'b0; txn_valid = 1'b0;
      check("R11", 32'(txn_deny), 1, "deny with clear");
      check("R11", 32'(irq_flag), 1, "set wins over clear");
      cfg_write(12'h010, 32'h1);
      @(negedge clk); check("R11", 32'(irq_flag), 0, "flag after lone clear");
      cfg_write(12'h050, 32'h0);

      // random rounds over R6..R10
      for (int round = 0; round < 4; round++) begin
         for (int r = 1; r < NR; r++) begin
            logic [30:0] bp, tp;
            bp = 31'($urandom % 56);
            tp = bp + 31'($urandom % 12);
            set_region(r, bp, tp, 2'($urandom), 1'($urandom), $urandom);
         end
         cfg_write(12'h064, {2'($urandom), 30'h0});
         cfg_write(12'h068, $urandom);
         flush();
         for (int r = 0; r < NR; r++) begin
            cfg_read(12'h064 + 12'(r * 32), rd);
            check("R4", rd, {m_as[r], 29'b0, m_ae[r]}, "attr readback");
         end
         for (int t = 0; t < 40; t++) begin
            logic [42:0] a;
            a = {12'h0, 19'($urandom % 72), 12'($urandom)};
            run_txn("R7", a, 1'($urandom), 1'($urandom), 4'($urandom));
         end
      end

      done = 1;
      summary();
      $finish;
   end
endmodule